// File: doc/BRIEF.md
# Non-Burst Bus Termination and Cache Control Glue

This block sits between a 486-class processor core and a slow, narrow memory and I/O bus. It watches the processor's cycle-start strobe. It waits for the far side to report that the transfer is finished, then closes the cycle by returning the non-burst ready strobe for a single clock. The burst ready strobe is never asserted. The processor gives the plain ready strobe priority over the burst one, so every cycle ends after its first transfer and no burst line fill ever runs. The on-chip cache still works: lines are filled one transfer at a time.

The block also decides cacheability. The cache-enable strobe is granted only to memory cycles whose page number (address bits 31:12) lies inside a RAM window set by parameters. It is withheld from I/O cycles and from every memory page outside the window.

Coherency with DMA is kept by a single cache-flush pulse issued when a DMA sequence starts. The pulse is not repeated for each DMA transfer, because a full flush stalls the processor. All processor-facing outputs are active low, come straight from flops, and are inactive after reset. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure: every pin is a plain control strobe.

Top module: `bus_term_glue`

## Requirements
- R1: While reset is applied and on the first clock after it, `rdy_n`, `brdy_n`, `ken_n` and `flush_n` are all high, and no cycle is in progress.
- R2: A cycle starts at a rising edge where `ads_n` is low and no cycle is in progress. `ext_rdy` is sampled high at some later edge, after any number of wait clocks. `rdy_n` is low for exactly the one clock that follows that edge, and it is high during every wait clock.
- R3: `ext_rdy` has no effect while no cycle is in progress: `rdy_n` stays high.
- R4: `brdy_n` is high at all times.
- R5: `ken_n` is low from the clock after the start edge through the clock in which `rdy_n` is low, provided `mem_io` = 1 (memory) and the page `cpu_page` is between `RAM_BASE` and `RAM_LIMIT`, both bounds inclusive. Otherwise it is high. `ken_n` does not change in the clock where `rdy_n` is low.
- R6: For an I/O cycle (`mem_io` = 0), `ken_n` stays high whatever the page.
- R7: In the clock after the one in which `rdy_n` is low, `ken_n` is high again, unless a new cycle started at that edge.
- R8: A rising edge of `dma_active` drives `flush_n` low for exactly one clock, in the clock after the edge where `dma_active` is first sampled high. No further pulse comes while `dma_active` stays high. A new pulse needs `dma_active` to go low and then high again.
- R9: A low `ads_n` while a cycle is in progress is ignored: no extra `rdy_n` pulse, and no change to the cycle's `ken_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Cycle-start strobe from the processor, active low |
| cpu_page | input | 20 | Address bits 31:12 of the current cycle |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| ext_rdy | input | 1 | Transfer-finished indication from the memory or I/O side, active high |
| dma_active | input | 1 | High while a DMA sequence owns the bus |
| rdy_n | output | 1 | Non-burst ready to the processor, active low |
| brdy_n | output | 1 | Burst ready to the processor, held high |
| ken_n | output | 1 | Cache enable to the processor, active low |
| flush_n | output | 1 | Cache flush request to the processor, active low |

## Verification
The bench builds the block with a narrow RAM window: pages 0x00100 to 0x001FF. Pages just below the base, exactly at the base, exactly at the limit and just above the limit can all be reached with a few cycles. This puts both inclusive bounds and both outside edges of the window decode under test. The default window, which reaches up to 16 MB, would leave those edges far from the addresses a short run uses. Wait counts from zero up to several clocks test the one-clock ready pulse and the timing of the cache-enable strobe, whatever the latency.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  localparam int PAGE_W = 20;

  typedef enum logic [0:0] {
    CYC_IDLE = 1'b0,
    CYC_BUSY = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/btg_cycle_fsm.sv
module btg_cycle_fsm
  import bus_term_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ads_n,
  input  logic ext_rdy,
  output logic start,
  output logic rdy_n
);
  cyc_state_e st;

  // a new cycle is only accepted while idle
  assign start = (st == CYC_IDLE) && !ads_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= CYC_IDLE;
      rdy_n <= 1'b1;
    end else begin
      rdy_n <= 1'b1;
      case (st)
        CYC_IDLE: if (start) st <= CYC_BUSY;
        CYC_BUSY: if (ext_rdy) begin
          st    <= CYC_IDLE;
          rdy_n <= 1'b0;
        end
        default: st <= CYC_IDLE;
      endcase
    end
  end

  // R2
  rdy_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> rdy_n);
  // R2
  rdy_follows_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(ext_rdy));
  // R3
  rdy_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(st == CYC_BUSY));
endmodule

// File: rtl/btg_cache_decode.sv
module btg_cache_decode
  import bus_term_pkg::*;
#(
  parameter logic [PAGE_W-1:0] RAM_BASE  = 20'h00100,
  parameter logic [PAGE_W-1:0] RAM_LIMIT = 20'h00FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_io,
  input  logic [PAGE_W-1:0] page,
  input  logic              rdy_n,
  output logic              ken_n
);
  logic in_win;
  assign in_win = (page >= RAM_BASE) && (page <= RAM_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ken_n <= 1'b1;
    else if (start)  ken_n <= !(mem_io && in_win);
    else if (!rdy_n) ken_n <= 1'b1;
  end

  // R6
  ken_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ken_n) |-> $past(mem_io) && $past(start));
  // R7
  ken_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && !start) |=> ken_n);
endmodule

// File: rtl/btg_flush_pulse.sv
module btg_flush_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_active,
  output logic flush_n
);
  logic dma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q   <= 1'b0;
      flush_n <= 1'b1;
    end else begin
      dma_q   <= dma_active;
      flush_n <= !(dma_active && !dma_q);
    end
  end

  // R8
  flush_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |=> flush_n);
  // R8
  flush_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |-> $past(dma_active));
endmodule

// File: rtl/bus_term_glue.sv
module bus_term_glue
  import bus_term_pkg::*;
#(
  parameter logic [PAGE_W-1:0] RAM_BASE  = 20'h00100,
  parameter logic [PAGE_W-1:0] RAM_LIMIT = 20'h00FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic [PAGE_W-1:0] cpu_page,
  input  logic              mem_io,
  input  logic              ext_rdy,
  input  logic              dma_active,
  output logic              rdy_n,
  output logic              brdy_n,
  output logic              ken_n,
  output logic              flush_n
);
  logic start;

  btg_cycle_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ads_n   (ads_n),
    .ext_rdy (ext_rdy),
    .start   (start),
    .rdy_n   (rdy_n)
  );

  btg_cache_decode #(
    .RAM_BASE  (RAM_BASE),
    .RAM_LIMIT (RAM_LIMIT)
  ) u_ken (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mem_io (mem_io),
    .page   (cpu_page),
    .rdy_n  (rdy_n),
    .ken_n  (ken_n)
  );

  btg_flush_pulse u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_active (dma_active),
    .flush_n    (flush_n)
  );

  // burst ready is parked inactive so every cycle ends on plain ready
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brdy_n <= 1'b1;
    else        brdy_n <= 1'b1;
  end

  // R5
  ken_stable_at_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> $stable(ken_n));
  // R4
  no_burst_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> brdy_n);
endmodule

// File: tb/tb_bus_term_glue.sv
module tb_bus_term_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1;
  logic [19:0] cpu_page = '0;
  logic        mem_io = 1'b0;
  logic        ext_rdy = 1'b0;
  logic        dma_active = 1'b0;
  logic        rdy_n, brdy_n, ken_n, flush_n;

  int checks = 0;
  int fails  = 0;
  int brdy_bad = 0;
  bit done = 1'b0;
  bit exp_q[$];

  always #5 clk = ~clk;

  bus_term_glue #(
    .RAM_BASE  (20'h00100),
    .RAM_LIMIT (20'h001FF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cpu_page(cpu_page),
    .mem_io(mem_io), .ext_rdy(ext_rdy), .dma_active(dma_active),
    .rdy_n(rdy_n), .brdy_n(brdy_n), .ken_n(ken_n), .flush_n(flush_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: every rdy_n low clock pops one expected cycle and compares ken_n
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (brdy_n !== 1'b1) brdy_bad++;
      if (rdy_n === 1'b0) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3/R9: got unexpected rdy_n low, expected none at %0t", $time);
        end else begin
          check("R5 ken at rdy", ken_n, exp_q.pop_front());
        end
      end
    end
  end

  // driver: one bus cycle with a given wait count
  task automatic run_cycle(input logic [19:0] pg, input logic mem,
                           input int waits, input bit stray_ads);
    logic exp_ken;
    exp_ken = !(mem && pg >= 20'h00100 && pg <= 20'h001FF);
    @(posedge clk); #1;
    ads_n = 1'b0; cpu_page = pg; mem_io = mem;
    exp_q.push_back(exp_ken);
    @(posedge clk); #1;                      // start edge
    ads_n = 1'b1; cpu_page = 20'hFFFFF; mem_io = ~mem;
    @(negedge clk);
    check("R5/R6 ken after start", ken_n, exp_ken);
    for (int i = 0; i < waits; i++) begin
      if (stray_ads && i == 0) ads_n = 1'b0; // R9 stimulus
      @(posedge clk); #1;
      ads_n = 1'b1;
      @(negedge clk);
      check("R2 rdy high while waiting", rdy_n, 1'b1);
      check("R9 ken held", ken_n, exp_ken);
    end
    ext_rdy = 1'b1;
    @(posedge clk); #1;
    ext_rdy = 1'b0;
    @(negedge clk);
    check("R2 rdy low", rdy_n, 1'b0);
    @(posedge clk); #1;
    @(negedge clk);
    check("R2 rdy one clock", rdy_n, 1'b1);
    check("R7 ken released", ken_n, 1'b1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdy reset", rdy_n, 1'b1);
    check("R1 brdy reset", brdy_n, 1'b1);
    check("R1 ken reset", ken_n, 1'b1);
    check("R1 flush reset", flush_n, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R1 rdy after reset", rdy_n, 1'b1);
    check("R1 flush after reset", flush_n, 1'b1);

    // R3: ext_rdy while idle
    ext_rdy = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      @(negedge clk);
      check("R3 idle ext_rdy ignored", rdy_n, 1'b1);
    end
    ext_rdy = 1'b0;

    // R5/R6 window edges and wait counts
    run_cycle(20'h000FF, 1'b1, 0, 1'b0);  // just below base
    run_cycle(20'h00100, 1'b1, 1, 1'b0);  // base
    run_cycle(20'h001FF, 1'b1, 4, 1'b0);  // limit
    run_cycle(20'h00200, 1'b1, 2, 1'b0);  // just above limit
    run_cycle(20'h00150, 1'b0, 3, 1'b0);  // I/O inside window
    run_cycle(20'h00180, 1'b1, 3, 1'b1);  // R9 stray ads during wait
    repeat (3) @(posedge clk);

    // R8 flush pulse
    @(posedge clk); #1;
    dma_active = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R8 flush low on rise", flush_n, 1'b0);
    @(posedge clk); #1;
    @(negedge clk);
    check("R8 flush one clock", flush_n, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8 no repeat while active", flush_n, 1'b1);
    @(posedge clk); #1;
    dma_active = 1'b0;
    repeat (2) @(posedge clk);
    #1 dma_active = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R8 flush on second rise", flush_n, 1'b0);
    @(posedge clk); #1;
    dma_active = 1'b0;
    @(negedge clk);
    check("R8 second pulse one clock", flush_n, 1'b1);

    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 brdy never low", (brdy_bad == 0), 1'b1);
    check("R2 all cycles answered", (exp_q.size() == 0), 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule